// File: doc/BRIEF.md
# Dual-Channel DAC Serial Write Front End

This block is the digital front end of a two-channel 12-bit converter. A host writes 16-bit commands over a write-only serial link made of a chip-select, a serial clock and a data line. The block samples these pins in its own clock domain and assembles each frame. On a complete frame it decodes the channel select, gain and power-state bits and stores the result in that channel's staging register.

A separate active-low load input copies both staging registers into the output registers in the same cycle. This lets the host load new values into both channels one after the other and then update both outputs together. Each channel presents a 12-bit code, a unity-gain flag and an active flag. Nothing can be read back over the link.

The pins are synchronised with a configurable number of flops. Edges on the serial clock and chip-select are detected in the system clock domain. The host must hold each pin level for more than `SYNC_STAGES + 2` system clocks.

Top module: `dual_dac_wr_if`

## Requirements
- R1: While reset is asserted, and after it is released, every channel output reads code 0, unity flag 0 and active flag 0 (powered down).
- R2: Frames are shifted in most significant bit first, one bit per rising edge of the serial clock while chip-select is low. Command bit 15 picks the channel (0 = A, 1 = B). Bit 14 has no effect.
- R3: Command bit 13 drives the unity flag (1 = unity gain, 0 = gain of two). Bit 12 drives the active flag (1 = active, 0 = powered down, output high-impedance).
- R4: Command bits 11 to 0 become the channel's 12-bit code.
- R5: A frame is committed to the staging register only when chip-select rises after at least 16 serial clock rising edges. With fewer edges, no register changes.
- R6: Serial clock edges after the 16th in one frame are ignored. The committed word is the first 16 bits.
- R7: Serial clock activity while chip-select is high shifts nothing in and does not count toward the next frame.
- R8: Frames work with the serial clock idling low and with it idling high.
- R9: While load is high, the channel outputs hold. Committed frames wait in the staging registers, and one load pulse updates both channels in the same cycle.
- R10: While load is held low, a newly committed frame reaches its channel's outputs without a separate pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dac_cs_n | input | 1 | Serial chip-select, active low |
| dac_sck | input | 1 | Serial clock from host |
| dac_sdi | input | 1 | Serial data from host |
| dac_load_n | input | 1 | Active-low transfer of staging to output registers |
| ch_a_code | output | 12 | Channel A output code |
| ch_a_unity | output | 1 | Channel A unity-gain flag |
| ch_a_active | output | 1 | Channel A active (not powered down) flag |
| ch_b_code | output | 12 | Channel B output code |
| ch_b_unity | output | 1 | Channel B unity-gain flag |
| ch_b_active | output | 1 | Channel B active flag |

## Verification
The bench drives a frame cut short at 15 clocks, a frame with no clocks, and a 20-clock frame whose trailing bits are ones. A design that commits short frames would corrupt channel A, and one that keeps shifting past 16 bits would store a different channel and code. Four clock pulses sent with chip-select high, followed by a 12-clock frame, catch a counter that keeps counting outside a frame, because that design would commit. Frames written while load stays high must leave both outputs frozen until one pulse moves both channels together. Frames are sent with both serial clock idle levels, and a second reset in mid-run must return the outputs to the powered-down zero state.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int CODE_W  = 12;
  localparam int FRAME_W = CODE_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int NUM_CH  = 2;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              unity;
    logic              active;
  } chan_cfg_t;

  localparam chan_cfg_t CFG_RESET = '{code: '0, unity: 1'b0, active: 1'b0};
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int        W       = 4,
  parameter int        STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_ns,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d;
      end else begin : g_rest
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_ns) begin
        if (!rst_ns) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dacif_frame_rx.sv
module dacif_frame_rx
  import dacif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             cs_n_s,
  input  logic             sck_s,
  input  logic             sdi_s,
  output logic             commit_vld,
  output logic             commit_sel,
  output chan_cfg_t        commit_cfg,
  output logic [CNT_W-1:0] bit_cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic               sck_q, cs_n_q;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               vld_q, vld_d;
  logic               sel_q, sel_d;
  chan_cfg_t          cfg_q, cfg_d;
  logic               sck_rise, cs_rise;

  assign sck_rise = sck_s & ~sck_q;
  assign cs_rise  = cs_n_s & ~cs_n_q;

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    vld_d   = 1'b0;
    sel_d   = sel_q;
    cfg_d   = cfg_q;
    if (cs_n_s) begin
      if (cs_rise && (cnt_q == FULL)) begin
        vld_d  = 1'b1;
        sel_d  = shreg_q[FRAME_W-1];
        cfg_d  = '{code:   shreg_q[CODE_W-1:0],
                   unity:  shreg_q[CODE_W+1],
                   active: shreg_q[CODE_W]};
      end
      cnt_d = '0;
    end else if (sck_rise && (cnt_q != FULL)) begin
      shreg_d = {shreg_q[FRAME_W-2:0], sdi_s};
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      shreg_q <= '0;
      cnt_q   <= '0;
      vld_q   <= 1'b0;
      sel_q   <= 1'b0;
      cfg_q   <= CFG_RESET;
    end else begin
      sck_q   <= sck_s;
      cs_n_q  <= cs_n_s;
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      vld_q   <= vld_d;
      sel_q   <= sel_d;
      cfg_q   <= cfg_d;
    end
  end

  assign commit_vld = vld_q;
  assign commit_sel = sel_q;
  assign commit_cfg = cfg_q;
  assign bit_cnt    = cnt_q;
endmodule

// File: rtl/dacif_chan_bank.sv
module dacif_chan_bank
  import dacif_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ns,
  input  logic      commit_vld,
  input  logic      commit_sel,
  input  chan_cfg_t commit_cfg,
  input  logic      ld_n_s,
  output chan_cfg_t out_cfg [NUM_CH]
);
  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
      chan_cfg_t stage_q, stage_d, out_q, out_d;
      logic      stage_en, out_en;

      assign stage_en = commit_vld && (commit_sel == ch[0]);
      assign out_en   = ~ld_n_s;

      always_comb begin
        stage_d = stage_q;
        if (stage_en) stage_d = commit_cfg;
        out_d = out_q;
        if (out_en) out_d = stage_q;
      end

      always_ff @(posedge clk or negedge rst_ns) begin
        if (!rst_ns) begin
          stage_q <= CFG_RESET;
          out_q   <= CFG_RESET;
        end else begin
          stage_q <= stage_d;
          out_q   <= out_d;
        end
      end

      assign out_cfg[ch] = out_q;
    end
  endgenerate
endmodule

// File: rtl/dual_dac_wr_if.sv
module dual_dac_wr_if
  import dacif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dac_cs_n,
  input  logic              dac_sck,
  input  logic              dac_sdi,
  input  logic              dac_load_n,
  output logic [CODE_W-1:0] ch_a_code,
  output logic              ch_a_unity,
  output logic              ch_a_active,
  output logic [CODE_W-1:0] ch_b_code,
  output logic              ch_b_unity,
  output logic              ch_b_active
);
  logic [1:0]       rst_ff;
  logic             rst_ns;
  logic [3:0]       pins_s;
  logic             cs_n_s, sck_s, sdi_s, ld_n_s;
  logic             commit_vld, commit_sel;
  chan_cfg_t        commit_cfg;
  logic [CNT_W-1:0] bit_cnt;
  chan_cfg_t        out_cfg [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_ns = rst_ff[1];

  dacif_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk    (clk),
    .rst_ns (rst_ns),
    .d      ({dac_cs_n, dac_sck, dac_sdi, dac_load_n}),
    .q      (pins_s)
  );
  assign {cs_n_s, sck_s, sdi_s, ld_n_s} = pins_s;

  dacif_frame_rx u_rx (
    .clk        (clk),
    .rst_ns     (rst_ns),
    .cs_n_s     (cs_n_s),
    .sck_s      (sck_s),
    .sdi_s      (sdi_s),
    .commit_vld (commit_vld),
    .commit_sel (commit_sel),
    .commit_cfg (commit_cfg),
    .bit_cnt    (bit_cnt)
  );

  dacif_chan_bank u_bank (
    .clk        (clk),
    .rst_ns     (rst_ns),
    .commit_vld (commit_vld),
    .commit_sel (commit_sel),
    .commit_cfg (commit_cfg),
    .ld_n_s     (ld_n_s),
    .out_cfg    (out_cfg)
  );

  assign ch_a_code   = out_cfg[0].code;
  assign ch_a_unity  = out_cfg[0].unity;
  assign ch_a_active = out_cfg[0].active;
  assign ch_b_code   = out_cfg[1].code;
  assign ch_b_unity  = out_cfg[1].unity;
  assign ch_b_active = out_cfg[1].active;
endmodule

// File: rtl/dacif_checker.sv
module dacif_checker
  import dacif_pkg::*;
(
  input logic              clk,
  input logic              rst_ns,
  input logic              cs_n_s,
  input logic              ld_n_s,
  input logic              commit_vld,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [CODE_W-1:0] a_code,
  input logic [CODE_W-1:0] b_code
);
  assert_cnt_saturates_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    bit_cnt <= CNT_W'(FRAME_W));

  assert_commit_needs_full_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    commit_vld |-> $past(bit_cnt) == CNT_W'(FRAME_W));

  assert_idle_cs_no_count_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    cs_n_s |=> bit_cnt == '0);

  assert_hold_without_load_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    ld_n_s |=> ($stable(a_code) && $stable(b_code)));

  assert_b_moves_on_load_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    !$stable(b_code) |-> $past(!ld_n_s));
endmodule

bind dual_dac_wr_if dacif_checker u_chk (
  .clk        (clk),
  .rst_ns     (rst_ns),
  .cs_n_s     (cs_n_s),
  .ld_n_s     (ld_n_s),
  .commit_vld (commit_vld),
  .bit_cnt    (bit_cnt),
  .a_code     (ch_a_code),
  .b_code     (ch_b_code)
);

// File: tb/tb_dual_dac_wr_if.sv
module tb_dual_dac_wr_if;
  localparam int HALF = 5;
  localparam int NV   = 9;
  // entry: {cmd[15:0], nclk[4:0], sck_idle_high, pulse_load}
  localparam logic [22:0] VEC [NV] = '{
    {16'h3ABC, 5'd16, 1'b0, 1'b1},
    {16'hD123, 5'd16, 1'b1, 1'b1},
    {16'h1FFF, 5'd16, 1'b0, 1'b0},
    {16'hA000, 5'd16, 1'b1, 1'b1},
    {16'h3555, 5'd15, 1'b0, 1'b1},
    {16'hB7E1, 5'd20, 1'b0, 1'b1},
    {16'h4000, 5'd16, 1'b1, 1'b1},
    {16'h8FFF, 5'd16, 1'b0, 1'b1},
    {16'h0001, 5'd0,  1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, sdi, load_n;
  logic [11:0] a_code, b_code;
  logic a_unity, a_active, b_unity, b_active;
  int   n_tests = 0, n_fail = 0;
  logic [13:0] stage_m [2];
  logic [13:0] out_m   [2];

  always #2 clk = ~clk;

  dual_dac_wr_if dut (
    .clk(clk), .rst_n(rst_n), .dac_cs_n(cs_n), .dac_sck(sck), .dac_sdi(sdi),
    .dac_load_n(load_n),
    .ch_a_code(a_code), .ch_a_unity(a_unity), .ch_a_active(a_active),
    .ch_b_code(b_code), .ch_b_unity(b_unity), .ch_b_active(b_active)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_both(input string req);
    check(req, {a_code, a_unity, a_active}, out_m[0]);
    check(req, {b_code, b_unity, b_active}, out_m[1]);
  endtask

  task automatic send_frame(input logic [15:0] cmd, input int nclk, input logic idle_hi);
    sck = idle_hi;
    wait_clk(HALF);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 16) ? cmd[15-i] : 1'b1;
      if (idle_hi) begin
        sck = 1'b0; wait_clk(HALF);
        sck = 1'b1; wait_clk(HALF);
      end else begin
        wait_clk(HALF);
        sck = 1'b1; wait_clk(HALF);
        sck = 1'b0;
      end
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(8);
    if (nclk >= 16) stage_m[cmd[15]] = cmd[13:0] == 14'h0 ? {12'h0, 2'b00} :
                                       {cmd[11:0], cmd[13], cmd[12]};
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    wait_clk(3);
    load_n = 1'b1;
    wait_clk(8);
    out_m[0] = stage_m[0];
    out_m[1] = stage_m[1];
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      stage_m[c] = '0;
      out_m[c]   = '0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; load_n = 1'b1;
    model_reset();
    wait_clk(4);
    check("R1 reset A", {a_code, a_unity, a_active}, 14'h0);
    check("R1 reset B", {b_code, b_unity, b_active}, 14'h0);
    rst_n = 1'b1;
    wait_clk(4);
    check_both("R1 after release");

    // vector walk: R2 R3 R4 channel/field decode, R5 abort, R6 overlong,
    // R8 both idle levels, R9 hold until load
    for (int v = 0; v < NV; v++) begin
      send_frame(VEC[v][22:7], int'(VEC[v][6:2]), VEC[v][1]);
      if (VEC[v][0]) pulse_load();
      check_both("R2 R3 R4 R5 R6 R8 R9 vector");
    end

    // R7: clocks with CS high, then a 12-clock frame must not commit
    for (int i = 0; i < 4; i++) begin
      sdi = 1'b1;
      wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
    end
    send_frame(16'h3777, 12, 1'b0);
    pulse_load();
    check_both("R7 idle clocks ignored");

    // R9: two staged writes, single load updates both at once
    send_frame(16'h3246, 16, 1'b0);
    send_frame(16'hB9AB, 16, 1'b1);
    check_both("R9 hold before load");
    load_n = 1'b0;
    wait_clk(4);
    check("R9 A updates", {a_code, a_unity, a_active}, {12'h246, 2'b11});
    check("R9 B same cycle", {b_code, b_unity, b_active}, {12'h9AB, 2'b11});
    out_m[0] = stage_m[0];
    out_m[1] = stage_m[1];

    // R10: load held low passes a new frame straight through
    send_frame(16'hA444, 16, 1'b0);
    out_m[1] = stage_m[1];
    check("R10 transparent load", {b_code, b_unity, b_active}, {12'h444, 2'b10});
    load_n = 1'b1;
    wait_clk(4);

    // R1: reset mid-run
    rst_n = 1'b0;
    wait_clk(2);
    model_reset();
    check_both("R1 mid-run reset");
    rst_n = 1'b1;
    wait_clk(4);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule